// File: doc/BRIEF.md
# Open-Drain Serial Clock Generator

This block produces the clock of a two-wire serial bus as an open-drain master. It never drives the line high. It has one output, `pullLow`. When that output is high, an external driver pulls the clock line low. When it is low, the line floats and a pull-up resistor lifts it. The block reads back the real line level, and one-cycle rise and fall pulses, from a synchronizer that sits outside it.

A controller asks for the clock shape it needs through three request inputs:

- a free-running toggle,
- a single drive-low,
- a single release-high.

When no request is present, the block holds the line where it is. A parameter sets the minimum number of system cycles the line must stay at one level. That hold is timed from the observed line edges, so another device that stretches the clock also stretches the measured phase.

If a release is requested but the line stays low, the block raises `cannotComply`. It does not pull the line while that flag is up.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset `pullLow` is 0 and `cannotComply` is 0, so the line reads high.
- R2: The minimum-hold timer restarts on every observed rise or fall pulse and whenever the block itself changes `pullLow`. It saturates at `MIN_STABLE`, and no transition of `pullLow` happens until it has saturated.
- R3: While `reqToggle` is held and nothing else stretches the line, the line alternates low and high. Each phase lasts exactly `MIN_STABLE`+2 system cycles: one cycle for the edge to be observed, `MIN_STABLE` cycles of hold, and one cycle to act.
- R4: Toggling starts within one cycle of `reqToggle` rising when the hold timer has expired, as it has after reset.
- R5: A `reqLow` request makes `pullLow` 1 within `MIN_STABLE`+3 cycles.
- R6: A `reqHigh` request given while the block pulls the line low releases it within `MIN_STABLE`+3 cycles.
- R7: When the requests switch from toggling to a single `reqHigh` or `reqLow`, the line settles at the requested level within `MIN_STABLE`+3 cycles and stays there.
- R8: If `reqHigh` is active, `pullLow` is 0 and the line is still observed low once the hold timer has expired, `cannotComply` becomes 1 within `MIN_STABLE`+3 cycles. While `cannotComply` is 1, `pullLow` stays 0.
- R9: `cannotComply` clears in the cycle after the line is observed high, and also when a `reqLow` or `reqToggle` request takes over.
- R10: With no request active, `pullLow` keeps its value on every cycle.
- R11: When requests overlap, the order of precedence is `reqToggle`, then `reqLow`, then `reqHigh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclLevel | input | 1 | Synchronized level of the clock line |
| sclRise | input | 1 | One-cycle pulse when the line is seen to rise |
| sclFall | input | 1 | One-cycle pulse when the line is seen to fall |
| reqToggle | input | 1 | Request a free-running clock |
| reqLow | input | 1 | Request the line driven low |
| reqHigh | input | 1 | Request the line released high |
| pullLow | output | 1 | 1 pulls the line low, 0 releases it |
| cannotComply | output | 1 | A release was requested but the line stays low |

## Verification
The assertions check the following on every cycle:
- the hold timer's saturation, and that `pullLow` stays still until the timer has expired (R2);
- that `pullLow` is held when no request is active (R10);
- that `pullLow` is never asserted while `cannotComply` is up (R8);
- that `cannotComply` clears after the line is seen high (R9);
- the precedence of a falling request, and of toggling over a falling request (R5, R11).

Only the bench's scenarios, with a model of the line that another device can hold low, can show the rest:
- the exact phase length of the toggle;
- that the line settles at the requested level after a mode switch;
- that the flag rises when the line is stretched during a release.

// File: rtl/scl_clock_gen_pkg.sv
package scl_clock_gen_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_RISE   = 2'd1,
    MODE_FALL   = 2'd2,
    MODE_TOGGLE = 2'd3
  } clkMode_t;

  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

endpackage

// File: rtl/scl_hold_timer.sv
module scl_hold_timer
  import scl_clock_gen_pkg::*;
#(
  parameter int MIN_STABLE = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  ctlStrobe_t strobe,
  output logic       stableDone
);
  localparam int CNT_W = $clog2(MIN_STABLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_STABLE);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= CNT_MAX;
    end else if (sclRise || sclFall || strobe.restart) begin
      holdCnt <= '0;
    end else if (holdCnt != CNT_MAX) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign stableDone = (holdCnt == CNT_MAX);

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_MAX) else $error("hold counter overran"); // R2

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise || sclFall) |=> (holdCnt == '0)) else $error("edge did not restart timer"); // R2

endmodule

// File: rtl/scl_clock_ctrl.sv
module scl_clock_ctrl
  import scl_clock_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLevel,
  input  logic       stableDone,
  input  logic       reqToggle,
  input  logic       reqLow,
  input  logic       reqHigh,
  output ctlStrobe_t strobe,
  output logic       pullLow,
  output logic       cannotComply
);
  clkMode_t mode;
  logic     nextPull;
  logic     nextFlag;

  always_comb begin
    if (reqToggle)    mode = MODE_TOGGLE;
    else if (reqLow)  mode = MODE_FALL;
    else if (reqHigh) mode = MODE_RISE;
    else              mode = MODE_IDLE;
  end

  always_comb begin
    nextPull       = pullLow;
    nextFlag       = cannotComply;
    strobe.restart = 1'b0;
    unique case (mode)
      MODE_TOGGLE: begin
        nextFlag = 1'b0;
        if (stableDone) begin
          if (pullLow) begin
            nextPull       = 1'b0;
            strobe.restart = 1'b1;
          end else if (sclLevel) begin
            nextPull       = 1'b1;
            strobe.restart = 1'b1;
          end
        end
      end
      MODE_FALL: begin
        nextFlag = 1'b0;
        if (stableDone && !pullLow) begin
          nextPull       = 1'b1;
          strobe.restart = 1'b1;
        end
      end
      MODE_RISE: begin
        if (stableDone) begin
          if (pullLow) begin
            nextPull       = 1'b0;
            strobe.restart = 1'b1;
          end else if (!sclLevel) begin
            nextFlag = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (sclLevel) nextFlag = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullLow      <= 1'b0;
      cannotComply <= 1'b0;
    end else begin
      pullLow      <= nextPull;
      cannotComply <= nextFlag;
    end
  end

  AST_HOLD_UNTIL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stableDone |=> $stable(pullLow)) else $error("transition before hold expired"); // R2

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!reqToggle && !reqLow && !reqHigh) |=> $stable(pullLow)) else $error("idle changed line"); // R10

  AST_NO_PULL_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cannotComply |-> !pullLow) else $error("pulling while flagged"); // R8

  AST_FLAG_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclLevel |=> !cannotComply) else $error("flag kept with line high"); // R9

  AST_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (reqLow && !reqToggle && stableDone) |=> pullLow) else $error("fall request ignored"); // R5

  AST_TOGGLE_OVER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (reqToggle && reqLow && stableDone && pullLow) |=> !pullLow) else $error("precedence broken"); // R11

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_clock_gen_pkg::*;
#(
  parameter int MIN_STABLE = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclLevel,
  input  logic sclRise,
  input  logic sclFall,
  input  logic reqToggle,
  input  logic reqLow,
  input  logic reqHigh,
  output logic pullLow,
  output logic cannotComply
);
  ctlStrobe_t strobe;
  logic       stableDone;

  scl_hold_timer #(.MIN_STABLE(MIN_STABLE)) i_timer (
    .clk        (clk),
    .rstN       (rstN),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .strobe     (strobe),
    .stableDone (stableDone)
  );

  scl_clock_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sclLevel     (sclLevel),
    .stableDone   (stableDone),
    .reqToggle    (reqToggle),
    .reqLow       (reqLow),
    .reqHigh      (reqHigh),
    .strobe       (strobe),
    .pullLow      (pullLow),
    .cannotComply (cannotComply)
  );

endmodule

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;
  localparam int M = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqToggle = 1'b0, reqLow = 1'b0, reqHigh = 1'b0;
  logic extHold = 1'b0;
  logic pullLow, cannotComply;
  logic line, prevLine;
  logic sclRise, sclFall;
  int   nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  // Model of the bus line and of the external edge detector.
  assign line    = !(pullLow || extHold);
  assign sclRise = line && !prevLine;
  assign sclFall = !line && prevLine;
  always @(posedge clk) prevLine <= rstN ? line : 1'b1;

  scl_clock_gen #(.MIN_STABLE(M)) i_scl_clock_gen (
    .clk(clk), .rstN(rstN), .sclLevel(line), .sclRise(sclRise), .sclFall(sclFall),
    .reqToggle(reqToggle), .reqLow(reqLow), .reqHigh(reqHigh),
    .pullLow(pullLow), .cannotComply(cannotComply)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setReq(input logic t, input logic l, input logic h);
    reqToggle = t; reqLow = l; reqHigh = h;
  endtask

  // Wait up to maxCyc negedges for the line to reach lvl; reports 1 when reached.
  task automatic waitLine(input logic lvl, input int maxCyc, output int ok);
    ok = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (line == lvl) begin ok = 1; break; end
    end
  endtask

  task automatic holdsLine(input string req, input logic lvl, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line != lvl) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 pullLow", pullLow, 0);
    check("R1 cannotComply", cannotComply, 0);
  endtask

  task automatic testToggle();
    int ok, len;
    logic cur;
    setReq(1, 0, 0);
    @(negedge clk);
    check("R4 toggle start", line, 0);
    waitLine(1'b1, 3 * M, ok);
    for (int p = 0; p < 4; p++) begin
      cur = line;
      len = 0;
      while (line == cur && len < 4 * M) begin
        @(negedge clk);
        len++;
      end
      check("R3 phase length", len, M + 2);
    end
    setReq(0, 0, 0);
    cur = line;
    holdsLine("R10 idle holds", cur, 20);
  endtask

  task automatic testFallRise();
    int ok;
    setReq(0, 1, 0);
    waitLine(1'b0, M + 3, ok);
    check("R5 fall reached", ok, 1);
    setReq(0, 0, 0);
    holdsLine("R5 stays low", 1'b0, 20);
    setReq(0, 0, 1);
    waitLine(1'b1, M + 3, ok);
    check("R6 rise reached", ok, 1);
    setReq(0, 0, 0);
    holdsLine("R6 stays high", 1'b1, 20);
  endtask

  task automatic testSwitch();
    int ok;
    setReq(1, 0, 0);
    repeat (3 * M + 1) @(negedge clk);
    setReq(0, 0, 1);
    waitLine(1'b1, M + 3, ok);
    check("R7 toggle to rise", ok, 1);
    holdsLine("R7 rise held", 1'b1, 3 * M);
    setReq(1, 0, 0);
    repeat (4 * M + 2) @(negedge clk);
    setReq(0, 1, 0);
    waitLine(1'b0, M + 3, ok);
    check("R7 toggle to fall", ok, 1);
    holdsLine("R7 fall held", 1'b0, 3 * M);
  endtask

  task automatic testStretch();
    int got = 0;
    setReq(0, 0, 1);
    repeat (M + 4) @(negedge clk);
    setReq(0, 0, 0);
    extHold = 1'b1;
    @(negedge clk);
    setReq(0, 0, 1);
    for (int i = 0; i < M + 3; i++) begin
      @(negedge clk);
      if (cannotComply) begin got = 1; break; end
    end
    check("R8 flag raised", got, 1);
    check("R8 no pull", pullLow, 0);
    extHold = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 clear on high", cannotComply, 0);
    extHold = 1'b1;
    repeat (M + 3) @(negedge clk);
    check("R8 flag again", cannotComply, 1);
    setReq(0, 1, 0);
    @(negedge clk);
    check("R9 clear by fall", cannotComply, 0);
    setReq(0, 0, 0);
    extHold = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testPriority();
    int ok, ch = 0;
    logic cur;
    setReq(0, 0, 1);
    waitLine(1'b1, 3 * M, ok);
    repeat (M + 3) @(negedge clk);
    setReq(1, 1, 1);
    cur = line;
    for (int i = 0; i < 3 * M + 6; i++) begin
      @(negedge clk);
      if (line != cur) begin ch++; cur = line; end
    end
    check("R11 toggle wins", (ch >= 2) ? 1 : 0, 1);
    setReq(0, 1, 1);
    waitLine(1'b0, M + 3, ok);
    check("R11 fall over rise", ok, 1);
    holdsLine("R11 fall held", 1'b0, 2 * M);
    setReq(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testToggle();
    testFallRise();
    testSwitch();
    testStretch();
    testPriority();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule